// File: doc/BRIEF.md
# Row-Relocating Configuration Memory Port

This block is the programming port of a row-organised configuration store. The store holds 1024 rows, and each row has 32 words of 32 bits. The host never addresses a single word of the store. It works through a staging buffer exactly one row wide. The host fills the staging buffer word by word, in any order, and can read it back word by word. A single command then copies the whole buffer into a store row, or copies a store row into the buffer, in one cycle.

Every row-level command passes its row number through an adder before the row is decoded. The adder adds one of two offset registers. Stores use the write offset and loads use the read offset. A configuration is always built as if it started at logical row 0, and the offset alone decides where it lands in the store. Loading a configuration therefore costs one offset update, then 32 word writes and one row store per row.

A partial update follows a fixed sequence:
1. Load the row into the buffer.
2. Overwrite only the words that change.
3. Store the row back.

If the row number plus the offset runs past the last row, the command is refused and an error is signalled.

Top module: `rr_cfg_port`

## Requirements
- R1: After reset, `rsp_valid`, `done` and `err` are low, and both offset registers are zero, so logical row r maps to physical row r.
- R2: Op 1 (put word) writes `cmd_wdata` into buffer word `cmd_addr[4:0]`, in any order. Op 2 (get word) returns buffer word `cmd_addr[4:0]` on `rsp_data` with `rsp_valid` high in the cycle after the command.
- R3: Op 4 (row store) copies all 32 buffer words into physical row `cmd_addr` + write offset. `done` pulses for one cycle in the cycle after the command.
- R4: Op 5 (row load) replaces all 32 buffer words with physical row `cmd_addr` + read offset. `done` pulses for one cycle in the cycle after the command.
- R5: Op 3 (set offset) loads `cmd_wdata[9:0]` into the write offset when `cmd_sel` is 0, or into the read offset when `cmd_sel` is 1. The other offset keeps its value.
- R6: A row store or row load whose row plus offset exceeds 1023 pulses `err` instead of `done`. It changes neither the store (no wrapped write) nor the buffer.
- R7: A load, a write to selected words and a store back to the same row leave every word that was not rewritten unchanged.
- R8: Ops 0, 6 and 7, and any cycle with `cmd_valid` low, change nothing and raise none of `rsp_valid`, `done` and `err`.
- R9: A row plus offset of exactly 1023 is accepted for both store and load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R2 to R8) |
| cmd_addr | input | 10 | Logical row, or buffer word index in bits 4:0 |
| cmd_sel | input | 1 | Offset register select for op 3 (0 write, 1 read) |
| cmd_wdata | input | 32 | Word data, or new offset in bits 9:0 |
| rsp_data | output | 32 | Buffer word returned by a get |
| rsp_valid | output | 1 | `rsp_data` valid, one cycle after a get |
| done | output | 1 | Row store or load completed |
| err | output | 1 | Row store or load refused due to row overflow |

## Verification
The assertions check on every cycle that:
- `done` and `err` never coincide.
- Every `rsp_valid` and `done` pulse traces back to a matching command one cycle earlier.
- Idle cycles stay quiet.
- An offset register changes only on its own select.
- The buffer never takes a word write and a row load together.

Only the directed scenarios can show the following:
- Relocation lands data on the intended physical row.
- A refused store leaves row 0 untouched rather than wrapping.
- The 1023 boundary is accepted.
- A read-modify-write keeps the words that were not rewritten.

// File: rtl/rr_cfg_pkg.sv
package rr_cfg_pkg;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_PUT_WORD  = 3'd1,
        OP_GET_WORD  = 3'd2,
        OP_SET_OFS   = 3'd3,
        OP_ROW_STORE = 3'd4,
        OP_ROW_LOAD  = 3'd5
    } rr_op_e;

endpackage

// File: rtl/rr_offset_unit.sv
module rr_offset_unit #(
    parameter int ROWS   = 1024,
    parameter int ROW_AW = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ofs_we,
    input  logic              ofs_sel,
    input  logic [ROW_AW-1:0] ofs_val,
    input  logic [ROW_AW-1:0] row_in,
    input  logic              use_rd,
    output logic [ROW_AW-1:0] phys_row,
    output logic              ovf
);

    localparam int SUM_W = ROW_AW + 1;

    typedef struct packed {
        logic [ROW_AW-1:0] wofs;
        logic [ROW_AW-1:0] rofs;
    } ofs_t;

    ofs_t ofs_d, ofs_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        ofs_d = ofs_q;
        if (ofs_we) begin
            if (ofs_sel) ofs_d.rofs = ofs_val;
            else         ofs_d.wofs = ofs_val;
        end
        sum      = {1'b0, row_in} + {1'b0, (use_rd ? ofs_q.rofs : ofs_q.wofs)};
        ovf      = (sum >= SUM_W'(ROWS));
        phys_row = sum[ROW_AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ofs_q <= '0;
        else        ofs_q <= ofs_d;
    end

    // R5: offsets hold unless written
    p_ofs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ofs_we |=> $stable(ofs_q));

    // R5: a write-offset update leaves the read offset alone
    p_wsel_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_we && !ofs_sel) |=> (ofs_q.wofs == $past(ofs_val)) && $stable(ofs_q.rofs));

    // R5: a read-offset update leaves the write offset alone
    p_rsel_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_we && ofs_sel) |=> (ofs_q.rofs == $past(ofs_val)) && $stable(ofs_q.wofs));

endmodule

// File: rtl/rr_stage_buf.sv
module rr_stage_buf #(
    parameter int WORDS  = 32,
    parameter int WORD_W = 32,
    parameter int IX_W   = $clog2(WORDS),
    parameter int ROW_W  = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put_en,
    input  logic [IX_W-1:0]   put_idx,
    input  logic [WORD_W-1:0] put_word,
    input  logic              load_en,
    input  logic [ROW_W-1:0]  load_row,
    input  logic [IX_W-1:0]   get_idx,
    output logic [WORD_W-1:0] get_word,
    output logic [ROW_W-1:0]  row_out
);

    logic [WORD_W-1:0] buf_d [WORDS];
    logic [WORD_W-1:0] buf_q [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            buf_d[i] = load_en ? load_row[i*WORD_W +: WORD_W] : buf_q[i];
        end
        if (put_en) buf_d[put_idx] = put_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) buf_q[i] <= '0;
        end else begin
            for (int i = 0; i < WORDS; i++) buf_q[i] <= buf_d[i];
        end
    end

    assign get_word = buf_q[get_idx];

    for (genvar g = 0; g < WORDS; g++) begin : g_flat
        assign row_out[g*WORD_W +: WORD_W] = buf_q[g];
    end

    // R7: the buffer takes either a word or a whole row in a cycle, never both
    p_one_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(put_en && load_en));

endmodule

// File: rtl/rr_row_array.sv
module rr_row_array #(
    parameter int ROWS   = 1024,
    parameter int ROW_AW = $clog2(ROWS),
    parameter int ROW_W  = 1024
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_AW-1:0] waddr,
    input  logic [ROW_W-1:0]  wdata,
    input  logic [ROW_AW-1:0] raddr,
    output logic [ROW_W-1:0]  rdata
);

    logic [ROW_W-1:0] mem_q [ROWS];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rr_cfg_port.sv
module rr_cfg_port #(
    parameter int ROWS   = 1024,
    parameter int WORDS  = 32,
    parameter int WORD_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd_op,
    input  logic [$clog2(ROWS)-1:0]    cmd_addr,
    input  logic                       cmd_sel,
    input  logic [WORD_W-1:0]          cmd_wdata,
    output logic [WORD_W-1:0]          rsp_data,
    output logic                       rsp_valid,
    output logic                       done,
    output logic                       err
);
    import rr_cfg_pkg::*;

    localparam int ROW_AW = $clog2(ROWS);
    localparam int IX_W   = $clog2(WORDS);
    localparam int ROW_W  = WORDS * WORD_W;

    typedef struct packed {
        logic              rsp_valid;
        logic [WORD_W-1:0] rsp_data;
        logic              done;
        logic              err;
    } resp_t;

    resp_t resp_d, resp_q;

    rr_op_e            op;
    logic              is_put, is_get, is_set, is_store, is_load, is_row;
    logic              ovf;
    logic [ROW_AW-1:0] phys_row;
    logic [WORD_W-1:0] get_word;
    logic [ROW_W-1:0]  stage_row, array_row;
    logic              arr_we, stage_ld;

    always_comb begin
        op       = rr_op_e'(cmd_op);
        is_put   = cmd_valid && (op == OP_PUT_WORD);
        is_get   = cmd_valid && (op == OP_GET_WORD);
        is_set   = cmd_valid && (op == OP_SET_OFS);
        is_store = cmd_valid && (op == OP_ROW_STORE);
        is_load  = cmd_valid && (op == OP_ROW_LOAD);
        is_row   = is_store || is_load;
        arr_we   = is_store && !ovf;
        stage_ld = is_load && !ovf;

        resp_d           = resp_q;
        resp_d.rsp_valid = is_get;
        if (is_get) resp_d.rsp_data = get_word;
        resp_d.done      = is_row && !ovf;
        resp_d.err       = is_row && ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    rr_offset_unit #(.ROWS(ROWS), .ROW_AW(ROW_AW)) i_ofs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ofs_we   (is_set),
        .ofs_sel  (cmd_sel),
        .ofs_val  (cmd_wdata[ROW_AW-1:0]),
        .row_in   (cmd_addr),
        .use_rd   (is_load),
        .phys_row (phys_row),
        .ovf      (ovf)
    );

    rr_stage_buf #(.WORDS(WORDS), .WORD_W(WORD_W), .IX_W(IX_W), .ROW_W(ROW_W)) i_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .put_en   (is_put),
        .put_idx  (cmd_addr[IX_W-1:0]),
        .put_word (cmd_wdata),
        .load_en  (stage_ld),
        .load_row (array_row),
        .get_idx  (cmd_addr[IX_W-1:0]),
        .get_word (get_word),
        .row_out  (stage_row)
    );

    rr_row_array #(.ROWS(ROWS), .ROW_AW(ROW_AW), .ROW_W(ROW_W)) i_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (phys_row),
        .wdata (stage_row),
        .raddr (phys_row),
        .rdata (array_row)
    );

    assign rsp_data  = resp_q.rsp_data;
    assign rsp_valid = resp_q.rsp_valid;
    assign done      = resp_q.done;
    assign err       = resp_q.err;

    // R6: completion and refusal are exclusive
    p_done_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R2: a response appears only after a get
    p_rsp_from_get_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(cmd_valid) && ($past(cmd_op) == 3'd2)));

    // R3: completion appears only after a row command
    p_done_from_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cmd_valid) && (($past(cmd_op) == 3'd4) || ($past(cmd_op) == 3'd5))));

    // R8: an idle cycle produces no response
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_valid) |-> (!done && !err && !rsp_valid));

    // R6: the store is never written during a refused row command
    p_no_wrap_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(!arr_we && !stage_ld));

endmodule

// File: tb/test_rr_cfg_port.sv
`timescale 1ns/1ps
module test_rr_cfg_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [9:0]  cmd_addr = '0;
    logic        cmd_sel = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] rsp_data;
    logic        rsp_valid, done, err;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    rr_cfg_port i_rr_cfg_port (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata),
        .rsp_data(rsp_data), .rsp_valid(rsp_valid), .done(done), .err(err)
    );

    function automatic logic [31:0] pat(int seed, int i);
        return (32'(seed) * 32'h9E3779B1) ^ (32'(i) * 32'h00010193) ^ 32'h5A5A0000;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on a falling edge; outputs of this command are visible on return
    task automatic issue(bit v, logic [2:0] op, logic [9:0] addr, bit sel, logic [31:0] d);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_addr = addr; cmd_sel = sel; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic fill(int seed);
        for (int i = 31; i >= 0; i--) issue(1, 3'd1, 10'(i), 0, pat(seed, i));
    endtask

    task automatic verify(int seed, string req);
        for (int i = 0; i < 32; i++) begin
            issue(1, 3'd2, 10'(i), 0, '0);
            check(rsp_valid && rsp_data == pat(seed, i), req, rsp_data, pat(seed, i));
        end
    endtask

    task automatic row_cmd(logic [2:0] op, int row, bit ok, string req);
        issue(1, op, 10'(row), 0, '0);
        check(done == ok && err == !ok, req, {30'd0, done, err}, {30'd0, ok, !ok});
    endtask

    task automatic set_ofs(bit sel, int val);
        issue(1, 3'd3, '0, sel, 32'(val));
    endtask

    task automatic t_reset;
        check(!rsp_valid && !done && !err, "R1", {29'd0, rsp_valid, done, err}, 32'd0);
    endtask

    task automatic t_words;
        fill(1);
        verify(1, "R2");
        issue(1, 3'd1, 10'd9, 0, 32'h1234_ABCD);
        issue(1, 3'd2, 10'd9, 0, '0);
        check(rsp_valid && rsp_data == 32'h1234_ABCD, "R2", rsp_data, 32'h1234_ABCD);
    endtask

    task automatic t_store_load;
        fill(10);
        row_cmd(3'd4, 5, 1, "R3");
        fill(11);
        row_cmd(3'd5, 5, 1, "R4");
        verify(10, "R1 R4");
    endtask

    task automatic t_offsets;
        set_ofs(0, 100);
        fill(20);
        row_cmd(3'd4, 3, 1, "R3");
        fill(21);
        row_cmd(3'd5, 103, 1, "R5");
        verify(20, "R5");
        set_ofs(1, 100);
        fill(22);
        row_cmd(3'd5, 3, 1, "R5");
        verify(20, "R5");
        set_ofs(0, 0);
        set_ofs(1, 0);
    endtask

    task automatic t_overflow;
        fill(40);
        row_cmd(3'd4, 0, 1, "R6");
        set_ofs(0, 1000);
        fill(41);
        row_cmd(3'd4, 24, 0, "R6");
        verify(41, "R6");
        row_cmd(3'd4, 23, 1, "R9");
        set_ofs(1, 1000);
        fill(42);
        row_cmd(3'd5, 23, 1, "R9");
        verify(41, "R9");
        row_cmd(3'd5, 30, 0, "R6");
        verify(41, "R6");
        set_ofs(0, 0);
        set_ofs(1, 0);
        row_cmd(3'd5, 0, 1, "R6");
        verify(40, "R6");
    endtask

    task automatic t_partial;
        logic [31:0] e;
        fill(30);
        row_cmd(3'd4, 50, 1, "R7");
        fill(31);
        row_cmd(3'd5, 50, 1, "R7");
        issue(1, 3'd1, 10'd7, 0, 32'hC0FF_EE07);
        issue(1, 3'd1, 10'd19, 0, 32'hC0FF_EE19);
        row_cmd(3'd4, 50, 1, "R7");
        fill(32);
        row_cmd(3'd5, 50, 1, "R7");
        for (int i = 0; i < 32; i++) begin
            e = (i == 7) ? 32'hC0FF_EE07 : (i == 19) ? 32'hC0FF_EE19 : pat(30, i);
            issue(1, 3'd2, 10'(i), 0, '0);
            check(rsp_valid && rsp_data == e, "R7", rsp_data, e);
        end
    endtask

    task automatic t_ignored;
        fill(60);
        issue(1, 3'd6, 10'd2, 0, 32'hDEAD_0006);
        check(!rsp_valid && !done && !err, "R8", {29'd0, rsp_valid, done, err}, 32'd0);
        issue(1, 3'd7, 10'd5, 1, 32'hDEAD_0007);
        check(!rsp_valid && !done && !err, "R8", {29'd0, rsp_valid, done, err}, 32'd0);
        issue(1, 3'd0, 10'd4, 0, 32'hDEAD_0000);
        check(!rsp_valid && !done && !err, "R8", {29'd0, rsp_valid, done, err}, 32'd0);
        issue(0, 3'd1, 10'd4, 0, 32'hDEAD_BEEF);
        check(!rsp_valid && !done && !err, "R8", {29'd0, rsp_valid, done, err}, 32'd0);
        issue(0, 3'd4, 10'd5, 0, '0);
        check(!done && !err, "R8", {30'd0, done, err}, 32'd0);
        issue(0, 3'd3, '0, 0, 32'd7);
        verify(60, "R8");
        row_cmd(3'd5, 5, 1, "R8");
        verify(10, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        fork
            begin
                t_words();
                t_store_load();
                t_offsets();
                t_overflow();
                t_partial();
                t_ignored();
            end
            begin
                repeat (150000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule